// File: doc/BRIEF.md
# Capture/Compare Timer Counter

This block is a 16-bit up-counter paired with one 16-bit companion register. A single role bit makes the companion register either a compare register or a capture register. The counter advances by one on each count-enable strobe from an external prescaler. A 2-bit operating-mode field selects what clears the counter:

- stopped, where the counter is held at zero;
- free running;
- clear-and-restart on a valid edge of the capture pin;
- clear-and-restart when the counter matches the companion register.

A software read request holds the counter still, so a multi-cycle read sees a stable value.

Two pins, a primary one and an alternate one, each pass through a two-flop synchronizer and an edge detector. A 2-bit edge-select code sets the pin's valid edge, which is the edge used to clear the counter. Capture always happens on the edge opposite to the valid edge. When both edges are valid, capture is disabled. In compare role, equality between the count and the register raises a one-cycle interrupt pulse once per match event.

Top module: `ccTimer`

## Requirements
- R1: After reset the count, the companion register and the interrupt output are all zero.
- R2: While the mode field is 00 (stopped), the count is cleared to 0 and stays there.
- R3: In mode 01 (free running), each cycle with countEn high adds one to the count, wrapping modulo 2^16. A cycle with countEn low leaves the count unchanged.
- R4: While rdReq is high, count strobes are ignored and the count holds its value.
- R5: In mode 10, a valid edge of the synchronized primary pin clears the count to 0, and counting resumes from 0. The valid edge is set by edgeSel: 00 = falling, 01 = rising, 11 = both, 10 = none.
- R6: In mode 11 with regRole = 0, an accepted count strobe while count equals the register loads 0 instead of count+1. The count therefore cycles through 0..register.
- R7: With regRole = 0, wrEn loads wrData into the register, and pin edges leave the register unchanged.
- R8: With regRole = 0 and a non-zero mode, matchIrq goes high for exactly one cycle, one cycle after count first equals the register. It stays low while the two remain equal.
- R9: With regRole = 1, the register captures on the edge opposite to the valid edge: edgeSel 00 captures on rising, 01 on falling, and 10 or 11 never capture. Pins are synchronized by two flops before edge detection.
- R10: capSrcSel = 0 takes capture edges from capPin, and 1 takes them from altPin. A capture loads the count of the same cycle, so a capture coinciding with a clear stores the pre-clear value.
- R11: With regRole = 1, a capture in the same cycle as wrEn wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| countEn | input | 1 | Count strobe from the prescaler |
| rdReq | input | 1 | Software read in progress; holds the count |
| opMode | input | 2 | 00 stop, 01 free run, 10 clear on pin edge, 11 clear on match |
| regRole | input | 1 | 0 compare, 1 capture |
| capSrcSel | input | 1 | Capture source: 0 capPin, 1 altPin |
| edgeSel | input | 2 | Valid-edge code |
| capPin | input | 1 | Primary asynchronous pin |
| altPin | input | 1 | Alternate asynchronous capture input |
| wrEn | input | 1 | Write strobe for the companion register |
| wrData | input | 16 | Write data |
| count | output | 16 | Counter value |
| regValue | output | 16 | Companion register value |
| matchIrq | output | 1 | One-cycle match interrupt pulse |

## Verification
A vector table walks all four edge-select codes against both rising and falling pin transitions in clear-on-edge mode with capture role. Each vector has a distinct preset count, so the bench can tell a clear, a capture and no action apart. Directed runs then cover several further cases:

- a free-running count with strobe gaps and a read hold;
- a match held for several cycles, which separates a single pulse from a level;
- a clear-on-match cycle, which checks the period and the pulse count;
- a simultaneous primary-pin clear with an alternate-pin capture, which shows whether the captured value is taken before or after the clear;
- a write that collides with a capture, which shows which one wins.

// File: rtl/ccTimerPkg.sv
package ccTimerPkg;

  typedef enum logic [1:0] {
    MODE_STOP      = 2'b00,
    MODE_FREE      = 2'b01,
    MODE_EDGE_CLR  = 2'b10,
    MODE_MATCH_CLR = 2'b11
  } modeE;

  typedef enum logic [1:0] {
    EDGE_FALL_VALID = 2'b00,
    EDGE_RISE_VALID = 2'b01,
    EDGE_NONE       = 2'b10,
    EDGE_BOTH_VALID = 2'b11
  } edgeCodeE;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic capLoad;
  } ctrlStrobeT;

endpackage

// File: rtl/ccTimerSync.sv
module ccTimerSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain <= '0;
      prevQ <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prevQ <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prevQ;
  assign fall = ~chain[STAGES-1] & prevQ;
endmodule

// File: rtl/ccTimerCtrl.sv
module ccTimerCtrl
  import ccTimerPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_PINS    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       countEn,
  input  logic       rdReq,
  input  logic [1:0] opMode,
  input  logic       regRole,
  input  logic       capSrcSel,
  input  logic [1:0] edgeSel,
  input  logic       capPin,
  input  logic       altPin,
  input  logic       matchEq,
  output ctrlStrobeT strobes
);
  logic [NUM_PINS-1:0] pinIn;
  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_PINS-1:0] pinFall;
  modeE     mode;
  edgeCodeE code;
  logic     validEdge;
  logic     capEdge;
  logic     srcRise;
  logic     srcFall;
  logic     stepOk;

  assign pinIn = {altPin, capPin};

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    ccTimerSync #(.STAGES(SYNC_STAGES)) syncI (
      .clk (clk),
      .rstN(rstN),
      .din (pinIn[p]),
      .rise(pinRise[p]),
      .fall(pinFall[p])
    );
  end

  assign mode    = modeE'(opMode);
  assign code    = edgeCodeE'(edgeSel);
  assign srcRise = capSrcSel ? pinRise[1] : pinRise[0];
  assign srcFall = capSrcSel ? pinFall[1] : pinFall[0];
  assign stepOk  = countEn & ~rdReq;

  always_comb begin
    unique case (code)
      EDGE_FALL_VALID: validEdge = pinFall[0];
      EDGE_RISE_VALID: validEdge = pinRise[0];
      EDGE_BOTH_VALID: validEdge = pinRise[0] | pinFall[0];
      default:         validEdge = 1'b0;
    endcase
  end

  always_comb begin
    unique case (code)
      EDGE_FALL_VALID: capEdge = srcRise;
      EDGE_RISE_VALID: capEdge = srcFall;
      default:         capEdge = 1'b0;
    endcase
  end

  always_comb begin
    strobes = '0;
    unique case (mode)
      MODE_STOP:      strobes.clrCnt = 1'b1;
      MODE_FREE:      strobes.incCnt = stepOk;
      MODE_EDGE_CLR: begin
        strobes.clrCnt = validEdge;
        strobes.incCnt = stepOk & ~validEdge;
      end
      MODE_MATCH_CLR: begin
        strobes.clrCnt = stepOk & matchEq & ~regRole;
        strobes.incCnt = stepOk & ~(matchEq & ~regRole);
      end
      default: strobes = '0;
    endcase
    strobes.capLoad = regRole & capEdge;
  end
endmodule

// File: rtl/ccTimerDatapath.sv
module ccTimerDatapath
  import ccTimerPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             regRole,
  input  logic [1:0]       opMode,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] regValue,
  output logic             matchEq,
  output logic             matchIrq
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic matchCond;
  logic matchPrev;

  assign matchEq   = (count == regValue);
  assign matchCond = matchEq & ~regRole & (opMode != 2'b00);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.clrCnt) begin
      count <= '0;
    end else if (strobes.incCnt) begin
      count <= count + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regValue <= '0;
    end else if (strobes.capLoad) begin
      regValue <= count;
    end else if (wrEn) begin
      regValue <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchPrev <= 1'b0;
      matchIrq  <= 1'b0;
    end else begin
      matchPrev <= matchCond;
      matchIrq  <= matchCond & ~matchPrev;
    end
  end
endmodule

// File: rtl/ccTimer.sv
module ccTimer
  import ccTimerPkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             rdReq,
  input  logic [1:0]       opMode,
  input  logic             regRole,
  input  logic             capSrcSel,
  input  logic [1:0]       edgeSel,
  input  logic             capPin,
  input  logic             altPin,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] regValue,
  output logic             matchIrq
);
  ctrlStrobeT strobes;
  logic       matchEq;

  ccTimerCtrl #(.SYNC_STAGES(SYNC_STAGES), .NUM_PINS(2)) ctrlI (
    .clk      (clk),
    .rstN     (rstN),
    .countEn  (countEn),
    .rdReq    (rdReq),
    .opMode   (opMode),
    .regRole  (regRole),
    .capSrcSel(capSrcSel),
    .edgeSel  (edgeSel),
    .capPin   (capPin),
    .altPin   (altPin),
    .matchEq  (matchEq),
    .strobes  (strobes)
  );

  ccTimerDatapath #(.WIDTH(WIDTH)) dpI (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .regRole (regRole),
    .opMode  (opMode),
    .count   (count),
    .regValue(regValue),
    .matchEq (matchEq),
    .matchIrq(matchIrq)
  );
endmodule

// File: rtl/ccTimerChk.sv
module ccTimerChk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             countEn,
  input logic             rdReq,
  input logic [1:0]       opMode,
  input logic             regRole,
  input logic             wrEn,
  input logic [WIDTH-1:0] count,
  input logic [WIDTH-1:0] regValue,
  input logic             matchIrq
);
  // R2
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 2'b00) |=> (count == '0));

  // R3
  free_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && !rdReq && opMode == 2'b01) |=> (count == WIDTH'($past(count) + 1)));

  // R3
  free_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!countEn && opMode == 2'b01) |=> $stable(count));

  // R4
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && opMode == 2'b01) |=> $stable(count));

  // R7
  compare_reg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regRole && !wrEn) |=> $stable(regValue));

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    matchIrq |=> !matchIrq);
endmodule

bind ccTimer ccTimerChk #(.WIDTH(WIDTH)) chkI (
  .clk     (clk),
  .rstN    (rstN),
  .countEn (countEn),
  .rdReq   (rdReq),
  .opMode  (opMode),
  .regRole (regRole),
  .wrEn    (wrEn),
  .count   (count),
  .regValue(regValue),
  .matchIrq(matchIrq)
);

// File: tb/ccTimer_tb_top.sv
`timescale 1ns/1ps
module ccTimer_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        countEn = 1'b0;
  logic        rdReq = 1'b0;
  logic [1:0]  opMode = 2'b00;
  logic        regRole = 1'b0;
  logic        capSrcSel = 1'b0;
  logic [1:0]  edgeSel = 2'b00;
  logic        capPin = 1'b0;
  logic        altPin = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] count;
  logic [15:0] regValue;
  logic        matchIrq;

  int checks = 0;
  int failures = 0;
  int irqCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ccTimer dut_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .rdReq(rdReq), .opMode(opMode),
    .regRole(regRole), .capSrcSel(capSrcSel), .edgeSel(edgeSel), .capPin(capPin),
    .altPin(altPin), .wrEn(wrEn), .wrData(wrData), .count(count),
    .regValue(regValue), .matchIrq(matchIrq)
  );

  always @(negedge clk) if (matchIrq) irqCnt++;

  // {edgeSel[1:0], rising transition, expect capture, expect clear}
  localparam logic [4:0] VEC [8] = '{
    {2'b00, 1'b1, 1'b1, 1'b0},
    {2'b00, 1'b0, 1'b0, 1'b1},
    {2'b01, 1'b1, 1'b0, 1'b1},
    {2'b01, 1'b0, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b0},
    {2'b10, 1'b0, 1'b0, 1'b0},
    {2'b11, 1'b1, 1'b0, 1'b1},
    {2'b11, 1'b0, 1'b0, 1'b1}
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [15:0] v);
    wrEn = 1'b1; wrData = v;
    tick(1);
    wrEn = 1'b0;
  endtask

  task automatic runCount(input int n);
    countEn = 1'b1;
    tick(n);
    countEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    check("R1 count", count, 16'h0);
    check("R1 reg", regValue, 16'h0);
    check("R1 irq", {15'h0, matchIrq}, 16'h0);
    rstN = 1'b1;
    tick(1);

    // R5 R9 edge code table
    for (int v = 0; v < 8; v++) begin
      automatic logic [1:0] es = VEC[v][4:3];
      automatic logic rise = VEC[v][2];
      automatic logic [15:0] n = 16'(3 + v);
      opMode = 2'b00; regRole = 1'b1; capSrcSel = 1'b0; edgeSel = es;
      capPin = ~rise;
      tick(5);
      writeReg(16'hBEEF);
      opMode = 2'b10;
      runCount(int'(n));
      capPin = rise;
      tick(5);
      check("R9 capture by edge code", regValue, VEC[v][1] ? n : 16'hBEEF);
      check("R5 clear by edge code", count, VEC[v][0] ? 16'h0 : n);
    end

    // R2 stop clears
    opMode = 2'b00; tick(1);
    check("R2 stopped count", count, 16'h0);
    countEn = 1'b1; tick(3); countEn = 1'b0;
    check("R2 stopped ignores strobes", count, 16'h0);

    // R3 free running with gaps, R4 read hold
    regRole = 1'b0; writeReg(16'hFFFF);
    opMode = 2'b01;
    runCount(4); tick(3); runCount(2);
    check("R3 free count with gaps", count, 16'd6);
    rdReq = 1'b1; runCount(3); rdReq = 1'b0;
    check("R4 read hold", count, 16'd6);
    runCount(2);
    check("R4 resume after read", count, 16'd8);

    // R7 R8 compare pulse once per event
    opMode = 2'b00; tick(1);
    writeReg(16'd5);
    irqCnt = 0;
    opMode = 2'b01;
    runCount(5); tick(6);
    check("R8 single pulse while equal", 16'(irqCnt), 16'd1);
    edgeSel = 2'b00; capPin = 1'b1; tick(5); capPin = 1'b0; tick(5);
    check("R7 compare reg ignores pins", regValue, 16'd5);
    runCount(5);
    check("R8 no pulse after leaving match", 16'(irqCnt), 16'd1);

    // R6 clear on match
    opMode = 2'b00; tick(1);
    writeReg(16'd4);
    irqCnt = 0;
    opMode = 2'b11;
    runCount(12); tick(2);
    check("R6 match-clear period", count, 16'd2);
    check("R8 pulses per match event", 16'(irqCnt), 16'd2);

    // R10 source select and pre-clear capture
    opMode = 2'b00; regRole = 1'b1; capSrcSel = 1'b1; edgeSel = 2'b00;
    capPin = 1'b0; altPin = 1'b0; tick(5);
    writeReg(16'hBEEF);
    opMode = 2'b01; capPin = 1'b1; tick(5);
    check("R10 primary pin ignored when alt selected", regValue, 16'hBEEF);
    opMode = 2'b10;
    runCount(7);
    capPin = 1'b0; altPin = 1'b1; tick(5);
    check("R10 pre-clear value captured", regValue, 16'd7);
    check("R10 count cleared by primary edge", count, 16'h0);

    // R11 capture beats write
    opMode = 2'b00; capSrcSel = 1'b0; altPin = 1'b0; tick(5);
    opMode = 2'b01; runCount(9);
    wrData = 16'h1234; wrEn = 1'b1; capPin = 1'b1;
    tick(3);
    wrEn = 1'b0; tick(2);
    check("R11 capture wins over write", regValue, 16'd9);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule